// File: doc/BRIEF.md
# Prioritized Preemptive Interrupt Controller

The block gathers a set of asynchronous interrupt request lines and tells a processor which of them to service next. Each line is brought into the clock domain through a synchronizer. Each line has its own configuration bit that selects whether a low-to-high or a high-to-low transition raises its request. A detected transition sets a single pending flag for that line. Each line also has a configurable priority value, and an arbiter picks the most urgent pending line.

The block keeps a small stack of the priority levels of the handlers now running. A candidate is offered to the processor only if nothing is running, or if it is strictly more urgent than the level on top of the stack. The processor pulses `ack` when it enters the offered handler, which pushes that level and clears the line's flag. It pulses `eos` when a handler returns, which pops the level so that the interrupted handler, and any request it was blocking, can continue. Context saving and software masking are outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the handler stack is empty, no line is pending and `req_valid` is 0.
- R2: Bit i of `cfg_edge_fall` selects the edge for line i: 0 means a low-to-high transition, 1 means a high-to-low transition; the opposite transition does nothing. With the default two synchronizer stages, a transition driven before a clock edge is first visible on `req_valid` after the third clock edge.
- R3: Line i's priority is `cfg_prio[i*PRIO_W +: PRIO_W]`, and a larger value is more urgent. The offered line (`req_id`, `req_prio`) is the pending line with the largest priority; among equal priorities the lowest line number wins.
- R4: `req_valid` is 1 when a line is pending, the stack is not full, and either the stack is empty or the offered priority is strictly greater than the top-of-stack level.
- R5: A pending line whose priority is less than or equal to the top-of-stack level is not offered; it stays pending until the stack level falls below it.
- R6: Each line has one pending flag; further selected transitions while it is set are lost, so a burst yields one service.
- R7: `ack` while `req_valid` is 1 pushes `req_prio` and clears the offered line's flag in that cycle; a selected transition landing on that same line in that same cycle leaves the flag set.
- R8: `eos` with a non-empty stack pops one level, restoring the preempted level as the comparison point; `eos` with an empty stack has no effect.
- R9: The stack holds `STACK_DEPTH` levels (default 4); while it is full, `req_valid` stays 0 until a level is popped.
- R10: `ack` while `req_valid` is 0 has no effect on the stack or the flags.
- R11: `ack` accepted together with `eos` in one cycle replaces the top level with the new priority and leaves the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Raw asynchronous request lines |
| cfg_prio | input | N_SRC*PRIO_W | Per-line priority fields, line i at bits i*PRIO_W upward |
| cfg_edge_fall | input | N_SRC | Per-line edge select, 1 = falling |
| req_valid | output | 1 | A request is offered to the processor |
| req_id | output | $clog2(N_SRC) | Number of the offered line |
| req_prio | output | PRIO_W | Priority of the offered line |
| ack | input | 1 | Processor enters the offered handler |
| eos | input | 1 | Processor returns from the current handler |

## Verification
The embedded properties check on every cycle that the stack depth never exceeds its bound, that an offered request always outranks the running level, and that a push, a pop, a simultaneous push and pop, or an ignored acknowledge moves the depth by exactly the right amount. The properties cannot see end-to-end behaviour. That includes the three-edge detection latency, the edge polarity, the ties between equal priorities, the loss of repeated edges, the re-arming of a flag when an edge lands in the same cycle as its acknowledge, and the order in which handlers resume after nested preemption. The bench checks these with directed scenarios, plus a long random run compared against a cycle model built from the requirements.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
   import prio_irq_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw,
   input  logic [N_SRC-1:0] pol_fall,
   output logic [N_SRC-1:0] hit
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_edge_detect: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain_q;
      logic                   last_q;
      logic                   now_lvl;
      edge_kind_e             kind;

      assign now_lvl = chain_q[SYNC_STAGES-1];
      assign kind    = edge_kind_e'(pol_fall[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
            last_q  <= now_lvl;
         end
      end

      always_comb begin
         case (kind)
            EDGE_FALL: hit[g] = last_q & ~now_lvl;
            default:   hit[g] = now_lvl & ~last_q;
         endcase
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_SRC  = 8,
   parameter int PRIO_W = 3,
   localparam int ID_W  = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        pend,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    any,
   output logic [ID_W-1:0]         best_id,
   output logic [PRIO_W-1:0]       best_prio
);
   if (N_SRC < 2) begin : g_bad_n
      $error("irq_arbiter: N_SRC must be at least 2");
   end

   // Scan from the top index down with >= so the lowest index wins ties.
   always_comb begin
      any       = 1'b0;
      best_id   = '0;
      best_prio = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (pend[k] && (!any || prio_flat[k*PRIO_W +: PRIO_W] >= best_prio)) begin
            any       = 1'b1;
            best_id   = ID_W'(k);
            best_prio = prio_flat[k*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_prio,
   output logic [PRIO_W-1:0] top_prio,
   output logic [CNT_W-1:0]  depth,
   output logic              empty,
   output logic              full
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_prio_stack: DEPTH must be at least 2");
   end

   logic [PRIO_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  top_idx, nxt_idx;

   assign top_idx  = IDX_W'(cnt_q - CNT_W'(1));
   assign nxt_idx  = IDX_W'(cnt_q);
   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign top_prio = empty ? '0 : slot_q[top_idx];
   assign depth    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      end else if (push && pop && !empty) begin
         slot_q[top_idx] <= push_prio;
      end else if (push && !full) begin
         slot_q[nxt_idx] <= push_prio;
         cnt_q           <= cnt_q + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R9
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R8
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R7
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC       = 8,
   parameter int PRIO_W      = 3,
   parameter int STACK_DEPTH = 4,
   parameter int SYNC_STAGES = 2,
   localparam int ID_W       = $clog2(N_SRC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        irq_in,
   input  logic [N_SRC*PRIO_W-1:0] cfg_prio,
   input  logic [N_SRC-1:0]        cfg_edge_fall,
   output logic                    req_valid,
   output logic [ID_W-1:0]         req_id,
   output logic [PRIO_W-1:0]       req_prio,
   input  logic                    ack,
   input  logic                    eos
);
   localparam int CNT_W = $clog2(STACK_DEPTH + 1);

   if (PRIO_W < 1) begin : g_bad_prio
      $error("prio_irq_ctrl: PRIO_W must be at least 1");
   end

   logic [N_SRC-1:0]  edge_hit, pend_q, clr_vec;
   logic              any_pend, stk_empty, stk_full, take, drop;
   logic [PRIO_W-1:0] top_prio;
   logic [CNT_W-1:0]  stk_depth;

   irq_edge_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (irq_in),
      .pol_fall (cfg_edge_fall),
      .hit      (edge_hit)
   );

   irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
      .pend      (pend_q),
      .prio_flat (cfg_prio),
      .any       (any_pend),
      .best_id   (req_id),
      .best_prio (req_prio)
   );

   assign req_valid = any_pend && !stk_full && (stk_empty || req_prio > top_prio);
   assign take      = ack && req_valid;
   assign drop      = eos && !stk_empty;

   always_comb begin
      clr_vec = '0;
      if (take) clr_vec[req_id] = 1'b1;
   end

   // Set wins over clear: an edge in the acknowledge cycle re-arms the flag.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | edge_hit;
   end

   irq_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) i_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take),
      .pop       (drop),
      .push_prio (req_prio),
      .top_prio  (top_prio),
      .depth     (stk_depth),
      .empty     (stk_empty),
      .full      (stk_full)
   );

   // R4
   outranks_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !stk_empty) |-> (req_prio > top_prio));

   // R10
   ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req_valid && !eos) |=> $stable(stk_depth));

   // R11
   swap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && drop) |=> ($stable(stk_depth) && top_prio == $past(req_prio)));

   // R7
   clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !edge_hit[req_id]) |=> !pend_q[$past(req_id)]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   localparam int N  = 8;
   localparam int PW = 3;
   localparam int SD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic [N*PW-1:0] cfg_prio = '0;
   logic [N-1:0]  cfg_edge_fall = '0;
   logic          req_valid;
   logic [2:0]    req_id;
   logic [PW-1:0] req_prio;
   logic          ack = 1'b0;
   logic          eos = 1'b0;

   int total = 0;
   int bad = 0;

   // model state
   bit [N-1:0] m_s1, m_s2, m_prev, m_pend;
   int         m_stk [SD];
   int         m_cnt;

   always #2 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_prio(cfg_prio),
      .cfg_edge_fall(cfg_edge_fall), .req_valid(req_valid), .req_id(req_id),
      .req_prio(req_prio), .ack(ack), .eos(eos)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lprio(int i);
      return int'(cfg_prio[i*PW +: PW]);
   endfunction

   // expected offer from model state (R3, R4, R9)
   task automatic model_offer(output bit v, output int id, output int pr);
      pr = -1; id = 0;
      for (int i = N - 1; i >= 0; i--)
         if (m_pend[i] && lprio(i) >= pr) begin pr = lprio(i); id = i; end
      v = (pr >= 0) && (m_cnt < SD) && (m_cnt == 0 || pr > m_stk[m_cnt-1]);
   endtask

   task automatic model_update();
      bit v; int id, pr;
      bit [N-1:0] hit;
      model_offer(v, id, pr);
      for (int i = 0; i < N; i++)
         hit[i] = cfg_edge_fall[i] ? (m_prev[i] && !m_s2[i]) : (m_s2[i] && !m_prev[i]);
      if (ack && v) m_pend[id] = 1'b0;
      m_pend = m_pend | hit;
      if (ack && v && eos && m_cnt > 0) m_stk[m_cnt-1] = pr;
      else if (ack && v) begin m_stk[m_cnt] = pr; m_cnt++; end
      else if (eos && m_cnt > 0) m_cnt--;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
   endtask

   task automatic scoreboard();
      bit v; int id, pr;
      model_offer(v, id, pr);
      chk(req_valid == v, "R4", int'(req_valid), int'(v));
      if (v && req_valid) begin
         chk(int'(req_id) == id, "R3", int'(req_id), id);
         chk(int'(req_prio) == pr, "R3", int'(req_prio), pr);
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      scoreboard();
   endtask

   task automatic settle();
      repeat (4) step();
   endtask

   task automatic expect_req(input string tag, input bit v, input int id);
      chk(req_valid == v, tag, int'(req_valid), int'(v));
      if (v) chk(int'(req_id) == id, tag, int'(req_id), id);
   endtask

   task automatic do_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   task automatic do_eos();
      eos = 1'b1; step(); eos = 1'b0;
   endtask

   task automatic lines_low();
      irq_in = '0; settle();
   endtask

   initial begin
      repeat (SD) m_stk[0] = 0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_cnt = 0;
      for (int i = 0; i < SD; i++) m_stk[i] = 0;
      // priorities per line: 1,1,3,5,5,2,6,7 ; all rising
      cfg_prio = {3'd7, 3'd6, 3'd2, 3'd5, 3'd5, 3'd3, 3'd1, 3'd1};
      repeat (3) @(negedge clk);
      expect_req("R1", 1'b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_req("R1", 1'b0, 0);

      // R2 latency and polarity
      irq_in[2] = 1'b1; step(); step();
      expect_req("R2", 1'b0, 0);
      step();
      expect_req("R2", 1'b1, 2);
      do_ack();
      expect_req("R7", 1'b0, 0);
      // R10: ack with nothing offered while stack [3]; line 5 (prio 2) blocked
      irq_in[5] = 1'b1; settle();
      expect_req("R5", 1'b0, 0);
      do_ack();
      // R4 preemption by line 3 (prio 5)
      irq_in[3] = 1'b1; settle();
      expect_req("R4", 1'b1, 3);
      do_ack();
      // R5 equal priority held
      irq_in[4] = 1'b1; settle();
      expect_req("R5", 1'b0, 0);
      do_eos();
      expect_req("R8", 1'b1, 4);
      do_ack();
      do_eos();
      expect_req("R5", 1'b0, 0);
      do_eos();
      expect_req("R10", 1'b1, 5);
      do_ack();
      do_eos();
      expect_req("R8", 1'b0, 0);
      // R8 eos on empty stack ignored
      do_eos();
      lines_low();
      irq_in[0] = 1'b1; settle();
      expect_req("R8", 1'b1, 0);
      do_ack(); do_eos();
      lines_low();

      // R2 falling polarity on line 6: rising does nothing, falling triggers
      cfg_edge_fall[6] = 1'b1;
      irq_in[6] = 1'b1; settle();
      expect_req("R2", 1'b0, 0);
      irq_in[6] = 1'b0; settle();
      expect_req("R2", 1'b1, 6);
      do_ack(); do_eos();
      cfg_edge_fall[6] = 1'b0; settle();

      // R3 tie: lines 3 and 4 both prio 5 -> line 3
      irq_in[4] = 1'b1; irq_in[3] = 1'b1; settle();
      expect_req("R3", 1'b1, 3);
      do_ack(); do_eos();
      expect_req("R3", 1'b1, 4);
      do_ack(); do_eos();
      lines_low();

      // R6 burst of three edges gives one service
      for (int k = 0; k < 3; k++) begin
         irq_in[0] = 1'b1; step(); step();
         irq_in[0] = 1'b0; step(); step();
      end
      settle();
      expect_req("R6", 1'b1, 0);
      do_ack();
      do_eos();
      settle();
      expect_req("R6", 1'b0, 0);

      // R7 edge in the ack cycle re-arms the flag
      irq_in[0] = 1'b1; settle();
      expect_req("R7", 1'b1, 0);
      irq_in[0] = 1'b0; step(); step();
      irq_in[0] = 1'b1; step(); step();
      ack = 1'b1; step(); ack = 1'b0;
      expect_req("R7", 1'b0, 0);
      do_eos();
      expect_req("R7", 1'b1, 0);
      do_ack(); do_eos();
      lines_low();

      // R9 fill the stack with prios 1,3,5,6 then prio 7 is held
      irq_in[0] = 1'b1; settle(); do_ack();
      irq_in[2] = 1'b1; settle(); do_ack();
      irq_in[3] = 1'b1; settle(); do_ack();
      irq_in[6] = 1'b1; settle(); do_ack();
      irq_in[7] = 1'b1; settle();
      expect_req("R9", 1'b0, 0);
      do_eos();
      expect_req("R9", 1'b1, 7);
      do_ack();
      repeat (4) do_eos();
      expect_req("R9", 1'b0, 0);
      lines_low();

      // R11 ack together with eos replaces the top
      irq_in[2] = 1'b1; settle(); do_ack();
      irq_in[7] = 1'b1; settle();
      expect_req("R11", 1'b1, 7);
      ack = 1'b1; eos = 1'b1; step(); ack = 1'b0; eos = 1'b0;
      irq_in[6] = 1'b1; settle();
      expect_req("R11", 1'b0, 0);
      do_eos();
      expect_req("R11", 1'b1, 6);
      do_ack(); do_eos();
      lines_low();

      // random phase against the model
      void'($urandom(32'h5EED));
      for (int c = 0; c < 3000; c++) begin
         if (c % 1000 == 0) begin
            cfg_prio      = {$urandom, $urandom} % (1 << (N*PW));
            cfg_edge_fall = N'($urandom);
         end
         irq_in = irq_in ^ N'($urandom & $urandom & $urandom);
         ack    = ($urandom % 3) == 0;
         eos    = ($urandom % 5) == 0;
         step();
      end
      ack = 1'b0; eos = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule